// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words over several clock cycles. A word has one sign bit, an 8-bit exponent biased by 127 and a 23-bit fraction with an implied leading 1. A request is a one-cycle `start_i` pulse with both operands and the subtract select. The block negates the second operand's sign when subtraction is selected. It screens the special encodings, aligns the smaller significand and keeps three extra low bits for rounding. It then adds or subtracts the magnitudes, normalizes, rounds to nearest-even and repacks the result. `done_o` pulses for one cycle when `result_o` carries the answer, and the result then holds until the next request finishes.

Special words take a short path that skips the arithmetic. Inputs with a zero exponent count as zero, so denormal inputs are flushed. Results too small for a normal exponent become a signed zero. Results too large become a signed infinity. Every NaN the block produces is the canonical quiet NaN 0x7FC00000.

Top module: `fp_addsub_seq`

## Requirements
- R1: While reset is held and right after it, `done_o` is 0 and `result_o` is 0x00000000.
- R2: A `start_i` pulse is taken only while the block is idle, and a pulse during an operation is ignored. `done_o` is high for exactly one cycle per operation. `result_o` keeps its value after `done_o` until the next operation completes.
- R3: With equal effective signs the magnitudes are added. A sum of 2 or more is shifted right once and its exponent incremented (1.0+1.0 = 0x40000000, 1.5+1.5 = 0x40400000, 1.0-(-1.0) = 0x40000000). `sub_i`=1 flips the sign of `b_i`.
- R4: With differing effective signs the smaller magnitude is subtracted from the larger. The result takes the sign of the larger operand and is shifted left one bit per cycle until its leading bit is 1 (1.0-0.75 = 0x3E800000, -1.0-(-0.75) = 0xBE800000).
- R5: The aligned operand keeps guard, round and sticky bits, and rounding is to nearest with ties to even. Examples: 0x3F800000+0x33800000 = 0x3F800000, 0x3F800000+0x33800001 = 0x3F800001 and 0x3F800001+0x33800000 = 0x3F800002.
- R6: A rounding carry out of the significand renormalizes and bumps the exponent (0x3FFFFFFF+0x33800000 = 0x40000000).
- R7: Subtracting equal finite magnitudes gives +0 (0x00000000), whatever the operand signs.
- R8: An operand with exponent field 0 is zero, so any fraction is flushed. x+0 returns x, with the sign flip applied when it is the second operand. Adding two zeros gives -0 (0x80000000) only when both effective signs are negative, and +0 otherwise.
- R9: Exponent field 255 with fraction 0 is infinity. Infinity plus a finite value returns that infinity. Infinities of equal effective sign give that infinity. Infinities of opposite effective sign give NaN 0x7FC00000.
- R10: Exponent field 255 with a nonzero fraction is NaN. Any NaN operand yields 0x7FC00000.
- R11: A finite result whose exponent reaches 255, either after normalization or after a rounding carry, becomes infinity with the result's sign (0x7F7FFFFF+0x7F7FFFFF = 0x7F800000, 0x7F7FFFFF+0x73000000 = 0x7F800000).
- R12: A nonzero result that would need an exponent below 1 becomes zero with the larger operand's sign (0x00800001-0x00800000 = 0x00000000, 0x80800001-0x80800000 = 0x80000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| start_i | input | 1 | Request pulse, taken when idle |
| sub_i | input | 1 | 1 selects a_i - b_i, 0 selects a_i + b_i |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result word, held until the next completion |

## Verification
The assertions assume that `start_i` and the operands are driven between clock edges and are valid in the cycle `start_i` is high. They also assume that nothing drives the block while its internal reset is still synchronizing. The bench drives all inputs on falling edges, raises `start_i` for a single cycle and waits for `done_o` before the next request. The one exception is a deliberate second pulse during an operation, which checks that the pulse is ignored. The operands are chosen to hit each path: the special-word paths, right and left normalization, exact ties and values just above a tie, rounding carries, and both exponent limits.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EW   = 8;
  localparam int FW   = 23;
  localparam int WW   = 1 + EW + FW;
  localparam int SW   = FW + 1;
  localparam int XW   = SW + 3;
  localparam int EMAX = (1 << EW) - 1;
  localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  typedef struct packed {
    logic          sgn;
    logic [EW-1:0] exp;
    logic [FW-1:0] frac;
    logic          zero;
    logic          inf;
    logic          nan;
  } fp_parts_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ADD, ST_NORM, ST_ROUND, ST_DONE
  } fsm_t;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [WW-1:0] word_i,
  output fp_parts_t     parts_o
);
  always_comb begin
    parts_o.sgn  = word_i[WW-1];
    parts_o.exp  = word_i[WW-2:FW];
    parts_o.frac = word_i[FW-1:0];
    parts_o.zero = (word_i[WW-2:FW] == '0);
    parts_o.inf  = (word_i[WW-2:FW] == EW'(EMAX)) && (word_i[FW-1:0] == '0);
    parts_o.nan  = (word_i[WW-2:FW] == EW'(EMAX)) && (word_i[FW-1:0] != '0);
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic [SW-1:0] sig_i,
  input  logic [EW-1:0] shift_i,
  output logic [XW-1:0] sig_o
);
  logic [XW-1:0] wide;
  logic [XW-1:0] mask;
  logic [XW-1:0] moved;
  logic          lost;

  always_comb begin
    wide  = {sig_i, 3'b000};
    mask  = (XW'(1) << shift_i) - XW'(1);
    moved = wide >> shift_i;
    lost  = |(wide & mask);
    if (shift_i >= EW'(XW)) begin
      sig_o = {{(XW-1){1'b0}}, 1'b1};
    end else begin
      sig_o = {moved[XW-1:1], moved[0] | lost};
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic          sgn_i,
  input  logic [EW+1:0] exp_i,
  input  logic [XW-1:0] sig_i,
  output logic [WW-1:0] word_o
);
  logic          bump;
  logic [SW:0]   mant;
  logic [EW+1:0] exp_f;
  logic [FW-1:0] frac_f;

  always_comb begin
    bump   = sig_i[2] & (sig_i[1] | sig_i[0] | sig_i[3]);
    mant   = {1'b0, sig_i[XW-1:3]} + (SW+1)'(bump);
    exp_f  = exp_i + (EW+2)'(mant[SW]);
    frac_f = mant[SW] ? mant[FW:1] : mant[FW-1:0];
    if (exp_f >= (EW+2)'(EMAX)) begin
      word_o = {sgn_i, {EW{1'b1}}, {FW{1'b0}}};
    end else begin
      word_o = {sgn_i, exp_f[EW-1:0], frac_f};
    end
  end
endmodule

// File: rtl/fp_addsub_seq.sv
module fp_addsub_seq
  import fpadd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sub_i,
  input  logic [31:0]   a_i,
  input  logic [31:0]   b_i,
  output logic          done_o,
  output logic [31:0]   result_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fsm_t          state_q, state_d;
  logic [WW-1:0] a_q, a_d, b_q, b_d, res_q, res_d;
  logic          sgn_q, sgn_d, esub_q, esub_d;
  logic [EW+1:0] exp_q, exp_d;
  logic [XW-1:0] big_q, big_d, small_q, small_d;
  logic [XW:0]   sig_q, sig_d;

  fp_parts_t pa, pb, pbig, psml;
  logic          a_wins;
  logic [EW-1:0] gap;
  logic [XW-1:0] small_al;
  logic [XW:0]   sum;
  logic [WW-1:0] rnd_word;

  fpadd_unpack u_unpack_a (.word_i(a_q), .parts_o(pa));
  fpadd_unpack u_unpack_b (.word_i(b_q), .parts_o(pb));

  always_comb begin
    a_wins = (a_q[WW-2:0] >= b_q[WW-2:0]);
    pbig   = a_wins ? pa : pb;
    psml   = a_wins ? pb : pa;
    gap    = pbig.exp - psml.exp;
    sum    = esub_q ? ({1'b0, big_q} - {1'b0, small_q})
                    : ({1'b0, big_q} + {1'b0, small_q});
  end

  fpadd_align u_align (
    .sig_i  ({1'b1, psml.frac}),
    .shift_i(gap),
    .sig_o  (small_al)
  );

  fpadd_round u_round (
    .sgn_i (sgn_q),
    .exp_i (exp_q),
    .sig_i (sig_q[XW-1:0]),
    .word_o(rnd_word)
  );

  always_comb begin
    state_d = state_q;
    a_d     = a_q;
    b_d     = b_q;
    res_d   = res_q;
    sgn_d   = sgn_q;
    esub_d  = esub_q;
    exp_d   = exp_q;
    big_d   = big_q;
    small_d = small_q;
    sig_d   = sig_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          a_d     = a_i;
          b_d     = {b_i[WW-1] ^ sub_i, b_i[WW-2:0]};
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        state_d = ST_DONE;
        if (pa.nan || pb.nan) begin
          res_d = QNAN;
        end else if (pa.inf && pb.inf) begin
          res_d = (pa.sgn != pb.sgn) ? QNAN : a_q;
        end else if (pa.inf) begin
          res_d = a_q;
        end else if (pb.inf) begin
          res_d = b_q;
        end else if (pa.zero && pb.zero) begin
          res_d = {pa.sgn & pb.sgn, {(WW-1){1'b0}}};
        end else if (pa.zero) begin
          res_d = b_q;
        end else if (pb.zero) begin
          res_d = a_q;
        end else begin
          big_d   = {1'b1, pbig.frac, 3'b000};
          small_d = small_al;
          sgn_d   = pbig.sgn;
          exp_d   = {2'b00, pbig.exp};
          esub_d  = pa.sgn ^ pb.sgn;
          state_d = ST_ADD;
        end
      end
      ST_ADD: begin
        if (sum == '0) begin
          res_d   = '0;
          state_d = ST_DONE;
        end else begin
          sig_d   = sum;
          state_d = ST_NORM;
        end
      end
      ST_NORM: begin
        if (sig_q[XW]) begin
          sig_d   = {1'b0, sig_q[XW:2], sig_q[1] | sig_q[0]};
          exp_d   = exp_q + (EW+2)'(1);
          state_d = ST_ROUND;
        end else if (sig_q[XW-1]) begin
          state_d = ST_ROUND;
        end else if (exp_q <= (EW+2)'(1)) begin
          res_d   = {sgn_q, {(WW-1){1'b0}}};
          state_d = ST_DONE;
        end else begin
          sig_d   = {sig_q[XW-1:0], 1'b0};
          exp_d   = exp_q - (EW+2)'(1);
        end
      end
      ST_ROUND: begin
        res_d   = rnd_word;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      sgn_q   <= 1'b0;
      esub_q  <= 1'b0;
      exp_q   <= '0;
      big_q   <= '0;
      small_q <= '0;
      sig_q   <= '0;
    end else begin
      state_q <= state_d;
      a_q     <= a_d;
      b_q     <= b_d;
      res_q   <= res_d;
      sgn_q   <= sgn_d;
      esub_q  <= esub_d;
      exp_q   <= exp_d;
      big_q   <= big_d;
      small_q <= small_d;
      sig_q   <= sig_d;
    end
  end

  assign done_o   = (state_q == ST_DONE);
  assign result_o = res_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE) |=> $stable(result_o));

  // R4
  larger_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ADD && esub_q) |-> (big_q >= small_q));

  // R3
  normalized_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ROUND) |-> (sig_q[XW-1] && !sig_q[XW]));

  // R10
  no_made_nan_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ROUND) |-> (rnd_word[WW-2:FW] != EW'(EMAX) || rnd_word[FW-1:0] == '0));
endmodule

// File: tb/fp_addsub_seq_tb.sv
module fp_addsub_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        done_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fp_addsub_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done_o; i++) @(negedge clk);
  endtask

  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic s, input logic [31:0] exp);
    launch(a, b, s);
    wait_done();
    check({tag, " done"}, {31'b0, done_o}, 32'd1);
    check(tag, result_o, exp);
  endtask

  task automatic t_reset();
    check("R1 done in reset", {31'b0, done_o}, 32'd0);
    check("R1 result in reset", result_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", {31'b0, done_o}, 32'd0);
    check("R1 result after reset", result_o, 32'h0);
  endtask

  task automatic t_handshake();
    launch(32'h3F800000, 32'h3F800000, 1'b0);
    a_i = 32'h40A00000; b_i = 32'h40A00000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check("R2 done", {31'b0, done_o}, 32'd1);
    check("R2 busy start ignored", result_o, 32'h40000000);
    @(negedge clk);
    check("R2 done one cycle", {31'b0, done_o}, 32'd0);
    repeat (4) @(negedge clk);
    check("R2 result held", result_o, 32'h40000000);
    check("R2 no extra done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_same_sign();
    run_op("R3 1+1", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000);
    run_op("R3 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000);
    run_op("R3 1-(-1)", 32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000);
    run_op("R3 1+0.5", 32'h3F800000, 32'h3F000000, 1'b0, 32'h3FC00000);
  endtask

  task automatic t_diff_sign();
    run_op("R4 1-0.75", 32'h3F800000, 32'h3F400000, 1'b1, 32'h3E800000);
    run_op("R4 -1-(-0.75)", 32'hBF800000, 32'hBF400000, 1'b1, 32'hBE800000);
    run_op("R4 5-3", 32'h40A00000, 32'h40400000, 1'b1, 32'h40000000);
    run_op("R4 0.75+(-1)", 32'h3F400000, 32'hBF800000, 1'b0, 32'hBE800000);
  endtask

  task automatic t_rounding();
    run_op("R5 tie even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000);
    run_op("R5 above half", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001);
    run_op("R5 tie odd up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002);
  endtask

  task automatic t_round_carry();
    run_op("R6 carry renorm", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000);
  endtask

  task automatic t_cancel();
    run_op("R7 x-x", 32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000);
    run_op("R7 -x+x", 32'hC0490FDB, 32'h40490FDB, 1'b0, 32'h00000000);
  endtask

  task automatic t_zeros();
    run_op("R8 0+1", 32'h00000000, 32'h3F800000, 1'b0, 32'h3F800000);
    run_op("R8 0-1", 32'h00000000, 32'h3F800000, 1'b1, 32'hBF800000);
    run_op("R8 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000);
    run_op("R8 +0+-0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000);
    run_op("R8 -0-+0", 32'h80000000, 32'h00000000, 1'b1, 32'h80000000);
    run_op("R8 denorm+1", 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000);
    run_op("R8 denorm pair", 32'h00000005, 32'h80000003, 1'b0, 32'h00000000);
  endtask

  task automatic t_infinity();
    run_op("R9 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000);
    run_op("R9 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000);
    run_op("R9 -inf+-inf", 32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000);
    run_op("R9 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000);
  endtask

  task automatic t_nan();
    run_op("R10 nan+1", 32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000);
    run_op("R10 1+nan", 32'h3F800000, 32'hFF812345, 1'b0, 32'h7FC00000);
    run_op("R10 nan-inf", 32'h7F800001, 32'h7F800000, 1'b1, 32'h7FC00000);
  endtask

  task automatic t_overflow();
    run_op("R11 max+max", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000);
    run_op("R11 round to inf", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000);
    run_op("R11 neg overflow", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000);
  endtask

  task automatic t_underflow();
    run_op("R12 pos underflow", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000);
    run_op("R12 neg underflow", 32'h80800001, 32'h80800000, 1'b1, 32'h80000000);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_handshake();
    t_same_sign();
    t_diff_sign();
    t_rounding();
    t_round_carry();
    t_cancel();
    t_zeros();
    t_infinity();
    t_nan();
    t_overflow();
    t_underflow();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule